// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

The block is a small data cache that sits between a processor load/store port and a slower lower-level memory. It holds 512 sets of two frames. Each frame stores one 4-byte block, a valid flag, a dirty flag and a tag. One bit per set records which way was used most recently. Both ways of the addressed set are compared in the same cycle. A load that hits returns its data in the cycle it is presented. A store that hits uses two cycles: the first checks the tag and the second writes the matching frame.

On a miss the cache raises its stall output. It picks the way that is not the recently-used one. If that frame holds modified data, the cache first sends the frame to the lower level and then fetches the requested block. Stores that miss also allocate a frame: the fetched block is merged with the store value. Because a block is one word wide, the merge replaces the whole block. When the fetch completes, the stall drops and the held request is replayed, so it completes as a hit.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until it sees `cpu_done`. The lower level accepts one block per transfer. A transfer completes on the clock edge where both `mem_req` and `mem_ready` are high.

Top module: `cache2w`

## Requirements
- R1: The byte address is split into three fields. Bits [1:0] are the block offset and have no effect on lookup. Bits [10:2] select one of 512 sets. Bits [31:11] form the tag. A block in set 0 and a block in set 511 with the same tag are both held at once.
- R2: After reset every frame is invalid, every recently-used bit is 0, and `cpu_stall`, `cpu_done` and `mem_req` are low. The first access to any block therefore misses.
- R3: An access hits when either way of the indexed set is valid and its tag equals the address tag. At most one way matches. A load hit raises `cpu_done` with `cpu_rdata` in the same cycle, with no stall.
- R4: A hit sets the set's recently-used bit to the way that hit (0 or 1). A completed fill sets it to the way just filled.
- R5: A fill always writes the way whose number differs from the set's recently-used bit.
- R6: A store that hits raises `cpu_done` in its second cycle, not its first. The write lands in the matching way only.
- R7: A store hit marks the frame dirty and causes no lower-level traffic.
- R8: A miss whose victim is invalid or clean causes exactly one lower-level read. A miss whose victim is valid and dirty first writes the victim block, at address {victim tag, index, 2'b00}. It then reads the new block.
- R9: A store miss reads the block and installs the store value as the block's data. The frame is left dirty. A fill caused by a load leaves the frame clean.
- R10: `cpu_stall` is high from the cycle the miss is detected until the fill transfer completes. The replayed access then completes as a hit.
- R11: While a lower-level transfer waits for `mem_ready`, `mem_req`, `mem_we` and `mem_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with done |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Miss in service |
| mem_req | output | 1 | Lower-level transfer request |
| mem_we | output | 1 | 1 = write back block, 0 = fetch block |
| mem_addr | output | 32 | Block-aligned address |
| mem_wdata | output | 32 | Block written back |
| mem_rdata | input | 32 | Fetched block |
| mem_ready | input | 1 | Transfer accepted this edge |

## Verification
The in-RTL assertions check these properties on every cycle:
- at most one way matches;
- a store write cycle only follows a hitting store lookup and never touches memory;
- a write-back is always followed by a fetch for the same set;
- the fill never lands in the recently-used way, and the recently-used bit points at the filled way afterwards;
- lower-level requests hold steady until accepted.

Some behaviour only the bench scenarios can show, because it depends on whole access streams:
- which way gets evicted after a particular run of hits;
- whether an eviction writes back the right address and the latest stored data;
- that a store miss leaves its value readable;
- that offsets and distant sets do not disturb one another.

A reference model predicts hit or miss, write-back traffic and load data for directed conflict sequences and for a random stream of loads and stores.

// File: rtl/cache2w.sv
module cache2w #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SETS = 512,
  parameter int OFFW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_done,
  output logic          cpu_stall,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  localparam int IW = $clog2(SETS);
  localparam int TW = AW - IW - OFFW;

  typedef enum logic [1:0] {S_LOOK, S_STW, S_WB, S_FILL} st_t;

  logic [TW-1:0]   tag_m [2][SETS];
  logic [DW-1:0]   dat_m [2][SETS];
  logic [SETS-1:0] vld [2];
  logic [SETS-1:0] drt [2];
  logic [SETS-1:0] mru;

  st_t           st_q;
  logic [IW-1:0] idx_q;
  logic [TW-1:0] tag_q, vtag_q;
  logic          way_q, we_q;

  logic [IW-1:0] idx;
  logic [TW-1:0] tg;
  logic [1:0]    hit_w;
  logic          hit, hway, vway, look, fill_done, unused_ok;

  assign idx       = cpu_addr[OFFW +: IW];
  assign tg        = cpu_addr[AW-1 -: TW];
  assign unused_ok = ^cpu_addr[OFFW-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_w[w] = vld[w][idx] && (tag_m[w][idx] == tg);
  end

  assign hit  = |hit_w;
  assign hway = hit_w[1];
  assign vway = ~mru[idx];
  assign look = (st_q == S_LOOK) && cpu_req;
  assign fill_done = (st_q == S_FILL) && mem_ready;

  assign cpu_rdata = dat_m[hway][idx];
  assign cpu_done  = (look && !cpu_we && hit) || (st_q == S_STW);
  assign cpu_stall = (look && !hit) || (st_q == S_WB) || (st_q == S_FILL);
  assign mem_req   = (st_q == S_WB) || (st_q == S_FILL);
  assign mem_we    = (st_q == S_WB);
  assign mem_addr  = (st_q == S_WB) ? {vtag_q, idx_q, {OFFW{1'b0}}}
                                    : {tag_q, idx_q, {OFFW{1'b0}}};
  assign mem_wdata = dat_m[way_q][idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_LOOK;
      vld[0] <= '0;
      vld[1] <= '0;
      drt[0] <= '0;
      drt[1] <= '0;
      mru    <= '0;
      idx_q  <= '0;
      tag_q  <= '0;
      vtag_q <= '0;
      way_q  <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      case (st_q)
        S_LOOK: if (cpu_req) begin
          idx_q <= idx;
          tag_q <= tg;
          we_q  <= cpu_we;
          if (hit) begin
            way_q <= hway;
            if (cpu_we) st_q <= S_STW;
            else mru[idx] <= hway;
          end else begin
            way_q  <= vway;
            vtag_q <= tag_m[vway][idx];
            st_q   <= (vld[vway][idx] && drt[vway][idx]) ? S_WB : S_FILL;
          end
        end
        S_STW: begin
          drt[way_q][idx_q] <= 1'b1;
          mru[idx_q]        <= way_q;
          st_q              <= S_LOOK;
        end
        S_WB: if (mem_ready) st_q <= S_FILL;
        S_FILL: if (mem_ready) begin
          vld[way_q][idx_q] <= 1'b1;
          drt[way_q][idx_q] <= we_q;
          mru[idx_q]        <= way_q;
          st_q              <= S_LOOK;
        end
        default: st_q <= S_LOOK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) begin
      tag_m[way_q][idx_q] <= tag_q;
      dat_m[way_q][idx_q] <= we_q ? cpu_wdata : mem_rdata;
    end else if (st_q == S_STW) begin
      dat_m[way_q][idx_q] <= cpu_wdata;
    end
  end

  a_r3_one_match: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> $onehot0(hit_w));
  a_r4_mru_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (mru[idx_q] == way_q));
  a_r5_fill_not_mru: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (way_q != mru[idx_q]));
  a_r6_store_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STW) |-> $past((st_q == S_LOOK) && cpu_req && cpu_we && hit));
  a_r7_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STW) |-> !mem_req);
  a_r8_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we && $stable(idx_q)));
  a_r10_stall_cover: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (cpu_stall && !cpu_done));
  a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/cache2w_test.sv
module cache2w_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_done, cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache2w uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_done(cpu_done), .cpu_stall(cpu_stall), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int n_chk = 0, n_err = 0;
  logic [31:0] mem_aa [logic [31:0]];
  logic [31:0] gold [logic [31:0]];
  int wb_cnt = 0, rd_cnt = 0, wait_c = 0;
  logic [31:0] wb_a = '0, wb_d = '0;

  bit        mv [2][512];
  bit        md [2][512];
  bit [20:0] mt [2][512];
  bit        mm [512];

  function automatic logic [31:0] hsh(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction
  function automatic logic [31:0] mget(input logic [31:0] k);
    return mem_aa.exists(k) ? mem_aa[k] : hsh(k);
  endfunction
  function automatic logic [31:0] gget(input logic [31:0] k);
    return gold.exists(k) ? gold[k] : hsh(k);
  endfunction
  function automatic logic [31:0] mk(input int t, input int i, input int o);
    return (32'(t) << 11) | (32'(i) << 2) | 32'(o & 3);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      wait_c = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
      wait_c = int'($urandom % 4);
    end else if (mem_req) begin
      if (wait_c == 0) begin
        mem_ready = 1'b1;
        if (mem_we) begin
          mem_aa[mem_addr] = mem_wdata;
          wb_cnt++;
          wb_a = mem_addr;
          wb_d = mem_wdata;
        end else begin
          mem_rdata = mget(mem_addr);
          rd_cnt++;
        end
      end else wait_c--;
    end
  end

  task automatic acc(input bit we, input logic [31:0] a, input logic [31:0] wd,
                     input string rq);
    int idx = int'(a[10:2]);
    bit [20:0] tg = a[31:11];
    logic [31:0] key = {a[31:2], 2'b00};
    bit eh, vw, ewb, st, dn, hw;
    logic [31:0] ewa, ewd, rd;
    int w0, r0, cyc;
    eh  = (mv[0][idx] && mt[0][idx] == tg) || (mv[1][idx] && mt[1][idx] == tg);
    hw  = mv[1][idx] && mt[1][idx] == tg;
    vw  = !mm[idx];
    ewb = !eh && mv[vw][idx] && md[vw][idx];
    ewa = {mt[vw][idx], 9'(idx), 2'b00};
    ewd = gget(ewa);
    w0 = wb_cnt; r0 = rd_cnt;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0; st = 0; dn = 0; rd = '0;
    while (!dn) begin
      #1;
      if (cpu_stall) st = 1;
      if (cpu_done) begin
        dn = 1;
        rd = cpu_rdata;
      end else begin
        @(negedge clk);
        cyc++;
        if (cyc > 300) begin
          chk(0, "R10", "access timeout", 32'(cyc), 32'd300);
          dn = 1;
        end
      end
    end
    chk(st == !eh, rq, "stall seen (miss)", 32'(st), 32'(!eh));
    chk((wb_cnt - w0) == int'(ewb), "R8", "write-back count",
        32'(wb_cnt - w0), 32'(ewb));
    if (ewb) begin
      chk(wb_a == ewa, "R8", "write-back address", wb_a, ewa);
      chk(wb_d == ewd, "R8", "write-back data", wb_d, ewd);
    end
    chk((rd_cnt - r0) == int'(!eh), "R8", "fetch count",
        32'(rd_cnt - r0), 32'(!eh));
    if (eh) chk(cyc == (we ? 1 : 0), we ? "R6" : "R3", "hit latency",
                32'(cyc), we ? 32'd1 : 32'd0);
    if (!we) chk(rd == gget(key), rq, "load data", rd, gget(key));
    if (!eh) begin
      mv[vw][idx] = 1; mt[vw][idx] = tg; md[vw][idx] = we;
      mm[idx] = vw; hw = vw;
    end
    mm[idx] = hw;
    if (we) begin
      md[hw][idx] = 1;
      gold[key] = wd;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "R10", "watchdog expired", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int sets [4];
    sets = '{0, 3, 511, 256};
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk(!cpu_stall && !mem_req && !cpu_done, "R2", "reset outputs",
        {29'd0, cpu_stall, mem_req, cpu_done}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!cpu_stall && !mem_req, "R2", "idle after reset",
        {30'd0, cpu_stall, mem_req}, 32'd0);

    acc(0, mk(1, 3, 0), 0, "R2");
    acc(0, mk(1, 3, 3), 0, "R1");
    acc(1, mk(1, 3, 1), 32'hCAFE0001, "R7");
    acc(0, mk(2, 3, 0), 0, "R5");
    acc(0, mk(1, 3, 2), 0, "R4");
    acc(0, mk(3, 3, 0), 0, "R5");
    acc(0, mk(1, 3, 0), 0, "R4");
    acc(0, mk(2, 3, 0), 0, "R5");
    acc(0, mk(3, 3, 0), 0, "R8");
    acc(0, mk(1, 3, 0), 0, "R8");
    acc(1, mk(7, 9, 0), 32'h1234ABCD, "R9");
    acc(0, mk(7, 9, 2), 0, "R9");
    acc(0, mk(8, 9, 0), 0, "R9");
    acc(0, mk(6, 9, 0), 0, "R9");
    acc(0, mk(7, 9, 0), 0, "R9");
    acc(0, mk(5, 0, 0), 0, "R1");
    acc(1, mk(5, 511, 0), 32'h00511511, "R1");
    acc(0, mk(5, 0, 1), 0, "R1");
    acc(0, mk(5, 511, 3), 0, "R1");
    acc(0, mk(4, 3, 0), 0, "R10");

    for (int i = 0; i < 600; i++) begin
      bit we = ($urandom % 3) == 0;
      int t = int'($urandom % 4) + ((i % 5 == 0) ? 1000 : 0);
      acc(we, mk(t, sets[$urandom % 4], int'($urandom % 4)), $urandom, "R3");
    end

    @(negedge clk);
    cpu_req = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(!mem_req && !cpu_stall, "R11", "quiet at end",
        {30'd0, mem_req, cpu_stall}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule